// File: doc/BRIEF.md
# Branch and Next-PC Selection Unit

This unit decides where a 16-bit word-addressed processor goes next and which return address it records. It takes the program counter as it stands at the last word of the current instruction, the value of the base register, the signed constant word, a decoded branch kind and the register indices. It then produces the next program counter, a write enable for the PC register, a link value with its destination register index, a taken flag and a one-cycle strobe that clears the interrupt-in-service flag.

The PC register is updated during the execute phase, or whenever a reset or an interrupt entry is requested. A reset request overrides everything else. An interrupt entry comes next: it redirects to the interrupt vector and saves the current PC into the dedicated interrupt link register. Normal branch selection has the lowest priority. Every branch kind writes its return address, whether or not the branch is taken. A register-indirect jump through the interrupt link register marks the end of interrupt service.

The unit is combinational. The caller owns the PC register, the register file and the phase sequencing.

Top module: `nextpc_select`

## Requirements
- R1: When `rstReq` is 1, `nextPc` equals the `RST_VEC` parameter and `pcWrEn` is 1. `linkWrEn`, `branchTaken` and `irqFlagClr` are 0, whatever the other inputs are.
- R2: When `irqReq` is 1 and `rstReq` is 0, `nextPc` equals `IRQ_VEC` and `pcWrEn` is 1. `linkWrEn` is 1, `linkAddr` equals `IRQ_REG` (default 6) and `linkVal` equals `pcCur`. `branchTaken` and `irqFlagClr` are 0.
- R3: In the execute phase, kind code 1 (branch-if-zero) is taken exactly when `raVal` is 0, and kind code 2 (branch-if-nonzero) is taken exactly when `raVal` is not 0. When either is taken, `nextPc` is `pcCur + 1 + constWord`.
- R4: In the execute phase, for kind code 0, codes 5 to 7, or a conditional branch that is not taken, `nextPc` is `pcCur + 1` and `branchTaken` is 0.
- R5: In the execute phase, kind code 3 (jump with offset) is always taken, with `nextPc` equal to `raVal + constWord`.
- R6: In the execute phase, kind code 4 (register jump) is always taken, with `nextPc` equal to `raVal`. `constWord` has no effect on the result.
- R7: In the execute phase, kind codes 1 to 4 set `linkWrEn` to 1, with `linkVal` equal to `pcCur + 1` and `linkAddr` equal to `rcIdx`, whether taken or not. Other codes leave `linkWrEn` at 0.
- R8: `irqFlagClr` is 1 only in the execute phase, for kind code 4 with `raIdx` equal to `IRQ_REG`, and with no reset or interrupt request. Other kinds, or other values of `raIdx`, leave it at 0.
- R9: All address sums wrap modulo 2^16, and `constWord` is taken as two's complement.
- R10: With `execPhase`, `rstReq` and `irqReq` all 0, `pcWrEn`, `linkWrEn`, `branchTaken` and `irqFlagClr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcCur | input | 16 | Address of the last word of the current instruction |
| raVal | input | 16 | Value of the base register |
| constWord | input | 16 | Signed constant word |
| branchKind | input | 3 | 0 none, 1 branch-if-zero, 2 branch-if-nonzero, 3 jump with offset, 4 register jump |
| raIdx | input | 3 | Index of the base register |
| rcIdx | input | 3 | Index of the link destination register |
| execPhase | input | 1 | High in the execute phase |
| rstReq | input | 1 | Reset request |
| irqReq | input | 1 | Qualified interrupt entry request |
| nextPc | output | 16 | Selected next program counter |
| pcWrEn | output | 1 | PC register write enable |
| linkVal | output | 16 | Value to write into the link register |
| linkAddr | output | 3 | Index of the link register to write |
| linkWrEn | output | 1 | Link register write enable |
| branchTaken | output | 1 | Branch redirected the PC |
| irqFlagClr | output | 1 | Clear the interrupt-in-service flag |

## Verification
The bench builds the unit with a reset vector of 0x0040 and an interrupt vector of 0x0080. Neither is 0, and the two differ, so a vector that is hard-coded, swapped, or confused with a sequential address shows up in the reset and interrupt checks. The data width and the interrupt link register keep their defaults of 16 and 6. This brings the wrap-around at 0xFFFF within reach, and so does the case where an interrupt-flag clear depends on index 6 and not on a neighbouring index.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_BEQZ = 3'd1,
    BK_BNEZ = 3'd2,
    BK_JOFS = 3'd3,
    BK_JREG = 3'd4
  } branchKind_e;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_TGT = 2'd1,
    SEL_RST = 2'd2,
    SEL_IRQ = 2'd3
  } nextSel_e;

  typedef struct packed {
    nextSel_e nextSel;
    logic     baseIsRa;
    logic     addConst;
    logic     linkWr;
    logic     linkIsIrq;
    logic     taken;
    logic     irqClr;
    logic     pcWr;
  } npsStrobe_t;

endpackage

// File: rtl/nps_ctrl.sv
module nps_ctrl
  import nps_pkg::*;
#(
  parameter int REG_AW  = 3,
  parameter int IRQ_REG = 6
) (
  input  logic [2:0]        branchKind,
  input  logic [REG_AW-1:0] raIdx,
  input  logic              raIsZero,
  input  logic              execPhase,
  input  logic              rstReq,
  input  logic              irqReq,
  output npsStrobe_t        strb
);

  localparam logic [REG_AW-1:0] IrqIdx = REG_AW'(IRQ_REG);

  logic isBranch;
  assign isBranch = (branchKind >= 3'(BK_BEQZ)) && (branchKind <= 3'(BK_JREG));

  always_comb begin
    strb         = '0;
    strb.nextSel = SEL_SEQ;
    if (rstReq) begin
      strb.nextSel = SEL_RST;
      strb.pcWr    = 1'b1;
    end else if (irqReq) begin
      strb.nextSel   = SEL_IRQ;
      strb.pcWr      = 1'b1;
      strb.linkWr    = 1'b1;
      strb.linkIsIrq = 1'b1;
    end else if (execPhase) begin
      strb.pcWr   = 1'b1;
      strb.linkWr = isBranch;
      case (branchKind)
        3'(BK_BEQZ): begin
          strb.taken    = raIsZero;
          strb.addConst = 1'b1;
        end
        3'(BK_BNEZ): begin
          strb.taken    = !raIsZero;
          strb.addConst = 1'b1;
        end
        3'(BK_JOFS): begin
          strb.taken    = 1'b1;
          strb.baseIsRa = 1'b1;
          strb.addConst = 1'b1;
        end
        3'(BK_JREG): begin
          strb.taken    = 1'b1;
          strb.baseIsRa = 1'b1;
          strb.irqClr   = (raIdx == IrqIdx);
        end
        default: ;
      endcase
      if (strb.taken) strb.nextSel = SEL_TGT;
    end
  end

  // R8
  always_comb begin
    if (strb.irqClr) begin
      irq_clr_kind_chk: assert (branchKind == 3'(BK_JREG) && execPhase && !rstReq && !irqReq)
        else $error("irqClr outside register jump");
    end
  end

endmodule

// File: rtl/nps_datapath.sv
module nps_datapath
  import nps_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          REG_AW  = 3,
  parameter int          IRQ_REG = 6,
  parameter logic [DATA_W-1:0] RST_VEC = '0,
  parameter logic [DATA_W-1:0] IRQ_VEC = DATA_W'(2)
) (
  input  logic [DATA_W-1:0] pcCur,
  input  logic [DATA_W-1:0] raVal,
  input  logic [DATA_W-1:0] constWord,
  input  logic [REG_AW-1:0] rcIdx,
  input  npsStrobe_t        strb,
  output logic              raIsZero,
  output logic [DATA_W-1:0] nextPc,
  output logic [DATA_W-1:0] linkVal,
  output logic [REG_AW-1:0] linkAddr
);

  localparam logic [DATA_W-1:0] One = DATA_W'(1);

  logic [DATA_W-1:0] seqPc;
  logic [DATA_W-1:0] baseVal;
  logic [DATA_W-1:0] offsVal;
  logic [DATA_W-1:0] tgtPc;

  assign raIsZero = (raVal == '0);
  assign seqPc    = pcCur + One;
  assign baseVal  = strb.baseIsRa ? raVal : seqPc;
  assign offsVal  = strb.addConst ? constWord : '0;
  assign tgtPc    = baseVal + offsVal;

  always_comb begin
    case (strb.nextSel)
      SEL_RST: nextPc = RST_VEC;
      SEL_IRQ: nextPc = IRQ_VEC;
      SEL_TGT: nextPc = tgtPc;
      default: nextPc = seqPc;
    endcase
  end

  assign linkVal  = strb.linkIsIrq ? pcCur : seqPc;
  assign linkAddr = strb.linkIsIrq ? REG_AW'(IRQ_REG) : rcIdx;

  // R4
  always_comb begin
    if (strb.nextSel == SEL_SEQ) begin
      seq_step_chk: assert (nextPc - pcCur == One)
        else $error("sequential step is not one word");
    end
  end

endmodule

// File: rtl/nextpc_select.sv
module nextpc_select #(
  parameter int          DATA_W  = 16,
  parameter int          REG_AW  = 3,
  parameter int          IRQ_REG = 6,
  parameter logic [DATA_W-1:0] RST_VEC = '0,
  parameter logic [DATA_W-1:0] IRQ_VEC = DATA_W'(2)
) (
  input  logic [DATA_W-1:0] pcCur,
  input  logic [DATA_W-1:0] raVal,
  input  logic [DATA_W-1:0] constWord,
  input  logic [2:0]        branchKind,
  input  logic [REG_AW-1:0] raIdx,
  input  logic [REG_AW-1:0] rcIdx,
  input  logic              execPhase,
  input  logic              rstReq,
  input  logic              irqReq,
  output logic [DATA_W-1:0] nextPc,
  output logic              pcWrEn,
  output logic [DATA_W-1:0] linkVal,
  output logic [REG_AW-1:0] linkAddr,
  output logic              linkWrEn,
  output logic              branchTaken,
  output logic              irqFlagClr
);

  import nps_pkg::*;

  npsStrobe_t strb;
  logic       raIsZero;

  nps_ctrl #(.REG_AW(REG_AW), .IRQ_REG(IRQ_REG)) u_ctrl (
    .branchKind(branchKind), .raIdx(raIdx), .raIsZero(raIsZero),
    .execPhase(execPhase), .rstReq(rstReq), .irqReq(irqReq), .strb(strb)
  );

  nps_datapath #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .IRQ_REG(IRQ_REG),
    .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_dp (
    .pcCur(pcCur), .raVal(raVal), .constWord(constWord), .rcIdx(rcIdx),
    .strb(strb), .raIsZero(raIsZero), .nextPc(nextPc),
    .linkVal(linkVal), .linkAddr(linkAddr)
  );

  assign pcWrEn      = strb.pcWr;
  assign linkWrEn    = strb.linkWr;
  assign branchTaken = strb.taken;
  assign irqFlagClr  = strb.irqClr;

  logic normExec;
  assign normExec = execPhase && !rstReq && !irqReq;

  always_comb begin
    // R1
    if (rstReq) begin
      reset_vec_chk: assert (nextPc == RST_VEC && pcWrEn && !linkWrEn && !irqFlagClr)
        else $error("reset selection wrong");
    end
    // R2
    if (irqReq && !rstReq) begin
      irq_entry_chk: assert (nextPc == IRQ_VEC && linkWrEn && linkVal == pcCur
                             && linkAddr == REG_AW'(IRQ_REG))
        else $error("interrupt entry wrong");
    end
    // R3
    if (normExec && branchKind == 3'(BK_BEQZ)) begin
      beqz_decide_chk: assert (branchTaken == (raVal == '0))
        else $error("branch-if-zero decision wrong");
    end
    // R7
    if (normExec && linkWrEn) begin
      link_ret_chk: assert (linkVal == pcCur + DATA_W'(1) && linkAddr == rcIdx)
        else $error("return link wrong");
    end
    // R10
    if (!execPhase && !rstReq && !irqReq) begin
      idle_quiet_chk: assert (!pcWrEn && !linkWrEn && !branchTaken && !irqFlagClr)
        else $error("strobes active outside execute");
    end
  end

endmodule

// File: tb/nextpc_select_tb.sv
module nextpc_select_tb;

  localparam logic [15:0] RV = 16'h0040;
  localparam logic [15:0] IV = 16'h0080;

  logic        clk = 1'b0;
  logic [15:0] pcCur, raVal, constWord;
  logic [2:0]  branchKind, raIdx, rcIdx;
  logic        execPhase, rstReq, irqReq;
  logic [15:0] nextPc, linkVal;
  logic [2:0]  linkAddr;
  logic        pcWrEn, linkWrEn, branchTaken, irqFlagClr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  nextpc_select #(.RST_VEC(RV), .IRQ_VEC(IV)) u_dut (
    .pcCur(pcCur), .raVal(raVal), .constWord(constWord), .branchKind(branchKind),
    .raIdx(raIdx), .rcIdx(rcIdx), .execPhase(execPhase), .rstReq(rstReq),
    .irqReq(irqReq), .nextPc(nextPc), .pcWrEn(pcWrEn), .linkVal(linkVal),
    .linkAddr(linkAddr), .linkWrEn(linkWrEn), .branchTaken(branchTaken),
    .irqFlagClr(irqFlagClr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [15:0] pc, input logic [15:0] ra,
                       input logic [15:0] cw, input logic [2:0] ai, input logic [2:0] ci,
                       input logic ex, input logic rs, input logic iq);
    @(negedge clk);
    branchKind = k; pcCur = pc; raVal = ra; constWord = cw;
    raIdx = ai; rcIdx = ci; execPhase = ex; rstReq = rs; irqReq = iq;
    #1;
  endtask

  task automatic t_reset();
    drive(3'd4, 16'h1234, 16'h5555, 16'h0007, 3'd6, 3'd2, 1'b1, 1'b1, 1'b1);
    chk("R1 nextPc", nextPc, RV);
    chk("R1 pcWrEn", pcWrEn, 1);
    chk("R1 linkWrEn", linkWrEn, 0);
    chk("R1 taken", branchTaken, 0);
    chk("R1 irqFlagClr", irqFlagClr, 0);
  endtask

  task automatic t_irq();
    drive(3'd1, 16'h0300, 16'h0000, 16'h0010, 3'd1, 3'd3, 1'b0, 1'b0, 1'b1);
    chk("R2 nextPc", nextPc, IV);
    chk("R2 linkVal", linkVal, 16'h0300);
    chk("R2 linkAddr", linkAddr, 6);
    chk("R2 linkWrEn", linkWrEn, 1);
    chk("R2 pcWrEn", pcWrEn, 1);
    chk("R2 taken", branchTaken, 0);
  endtask

  task automatic t_cond();
    drive(3'd1, 16'h0100, 16'h0000, 16'h0020, 3'd1, 3'd5, 1'b1, 1'b0, 1'b0);
    chk("R3 beqz taken", branchTaken, 1);
    chk("R3 beqz target", nextPc, 16'h0121);
    drive(3'd1, 16'h0100, 16'h0001, 16'h0020, 3'd1, 3'd5, 1'b1, 1'b0, 1'b0);
    chk("R3 beqz not taken", branchTaken, 0);
    chk("R4 beqz fallthrough", nextPc, 16'h0101);
    chk("R7 link when not taken", linkVal, 16'h0101);
    chk("R7 linkWrEn not taken", linkWrEn, 1);
    chk("R7 linkAddr", linkAddr, 5);
    drive(3'd2, 16'h0200, 16'h8000, 16'hFFF0, 3'd2, 3'd4, 1'b1, 1'b0, 1'b0);
    chk("R3 bnez taken", branchTaken, 1);
    chk("R3 bnez negative offset", nextPc, 16'h01F1);
    drive(3'd2, 16'h0200, 16'h0000, 16'hFFF0, 3'd2, 3'd4, 1'b1, 1'b0, 1'b0);
    chk("R3 bnez not taken", branchTaken, 0);
    chk("R4 bnez fallthrough", nextPc, 16'h0201);
  endtask

  task automatic t_plain();
    drive(3'd0, 16'h0456, 16'h0000, 16'h0033, 3'd6, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R4 none nextPc", nextPc, 16'h0457);
    chk("R4 none taken", branchTaken, 0);
    chk("R7 none linkWrEn", linkWrEn, 0);
    chk("R8 none ra6 no clear", irqFlagClr, 0);
    for (int k = 5; k < 8; k++) begin
      drive(3'(k), 16'h0600, 16'h0000, 16'h0001, 3'd6, 3'd1, 1'b1, 1'b0, 1'b0);
      chk("R4 unused code nextPc", nextPc, 16'h0601);
      chk("R7 unused code linkWrEn", linkWrEn, 0);
    end
  endtask

  task automatic t_jumps();
    drive(3'd3, 16'h0700, 16'h2000, 16'hFFFE, 3'd6, 3'd7, 1'b1, 1'b0, 1'b0);
    chk("R5 jofs target", nextPc, 16'h1FFE);
    chk("R5 jofs taken", branchTaken, 1);
    chk("R7 jofs link", linkVal, 16'h0701);
    chk("R8 jofs ra6 no clear", irqFlagClr, 0);
    drive(3'd4, 16'h0800, 16'h3456, 16'h1111, 3'd3, 3'd2, 1'b1, 1'b0, 1'b0);
    chk("R6 jreg target", nextPc, 16'h3456);
    chk("R6 jreg taken", branchTaken, 1);
    chk("R8 jreg ra3 no clear", irqFlagClr, 0);
    drive(3'd4, 16'h0800, 16'h3456, 16'h9999, 3'd3, 3'd2, 1'b1, 1'b0, 1'b0);
    chk("R6 jreg const ignored", nextPc, 16'h3456);
    chk("R7 jreg link", linkVal, 16'h0801);
  endtask

  task automatic t_irqclr();
    drive(3'd4, 16'h0900, 16'h0042, 16'h0000, 3'd6, 3'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 jreg ra6 clear", irqFlagClr, 1);
    chk("R8 jreg ra6 target", nextPc, 16'h0042);
    drive(3'd4, 16'h0900, 16'h0042, 16'h0000, 3'd7, 3'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 jreg ra7 no clear", irqFlagClr, 0);
    drive(3'd4, 16'h0900, 16'h0042, 16'h0000, 3'd6, 3'd0, 1'b0, 1'b0, 1'b0);
    chk("R8 no clear outside execute", irqFlagClr, 0);
  endtask

  task automatic t_wrap();
    drive(3'd0, 16'hFFFF, 16'h0000, 16'h0000, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R9 seq wrap", nextPc, 16'h0000);
    drive(3'd1, 16'hFFFE, 16'h0000, 16'h0005, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R9 cond wrap", nextPc, 16'h0004);
    drive(3'd3, 16'h0010, 16'hFFF0, 16'h0020, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R9 jofs wrap", nextPc, 16'h0010);
  endtask

  task automatic t_idle();
    drive(3'd3, 16'h0A00, 16'h0000, 16'h0004, 3'd6, 3'd1, 1'b0, 1'b0, 1'b0);
    chk("R10 pcWrEn", pcWrEn, 0);
    chk("R10 linkWrEn", linkWrEn, 0);
    chk("R10 taken", branchTaken, 0);
  endtask

  initial begin
    t_reset();
    t_irq();
    t_cond();
    t_plain();
    t_jumps();
    t_irqclr();
    t_wrap();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule